// File: doc/BRIEF.md
# Write-back three-state snooping controller

This block keeps one processor's direct-mapped, write-back cache coherent with the other caches on a shared snooping bus. Every line is tracked in one of three states: Invalid, Valid (clean, possibly held by other caches too) and Modified (dirty, the only copy). The processor issues reads, writes and replacements against line addresses. The controller answers hits locally, stalls the processor on misses, and places bus reads, read-exclusive (read-to-own) requests and write-backs on the bus. Each line holds one data word, and a write replaces the whole word.

At the same time the controller watches bus reads and read-exclusives issued by other agents. A foreign request that finds a dirty copy here makes this cache supply the line on a separate flush port. A foreign read-exclusive removes the local copy. Snoops are handled on every cycle, including cycles in which a processor request is waiting for the bus. A snoop that touches the same index as a request that is about to complete locally holds that request back for one cycle.

A line address is `{tag, index}`, with the index in the low bits. The bus grant also acts as the completion of the transaction. Read data arrives on `bus_rdata` in the grant cycle. The bus serialises transactions, so a snoop that arrives together with a grant is disregarded.

Top module: `wb_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid. `line_state` carries line i in bits [2i+1:2i], encoded Invalid=0, Valid=1, Modified=2.
- R2: A read (`cpu_op`=0) that misses an Invalid line issues exactly one bus read (`bus_cmd`=1) for the requested address. The processor gets the word returned on `bus_rdata`, and the line becomes Valid.
- R3: A write (`cpu_op`=1) to an Invalid line, or to a Valid line with a matching tag, issues exactly one read-exclusive (`bus_cmd`=2). The line then becomes Modified and holds the written word.
- R4: A write that hits a Modified line, and a read that hits a Valid or Modified line, complete in the request cycle with `cpu_hit` high, no stall and no bus request. A read hit returns the line's current word.
- R5: A replacement (`cpu_op`=2) of a Modified line issues one write-back (`bus_cmd`=3) carrying the line's address and data, and the line becomes Invalid. Replacing a Valid line uses no bus transaction and leaves the line Invalid.
- R6: A read or write miss whose index holds a Modified line with another tag first writes back the old line to its own address. It then issues the bus read or read-exclusive for the new address.
- R7: A snooped read (`snp_cmd`=1) that hits a Modified line raises `flush_vld` in the next cycle, with the line address and data, and the line becomes Valid.
- R8: A snooped read-exclusive (`snp_cmd`=2) makes a hit line Invalid. It flushes the data in the next cycle only if the line was Modified. A snooped read that hits a Valid line changes nothing.
- R9: A snooped read-exclusive to the line being upgraded, arriving before grant, makes the line Invalid. The write stays stalled and completes at grant, leaving the line Modified with the written word.
- R10: While a write-back is waiting for grant, the processor stays stalled and a snoop hitting another index is still serviced.
- R11: A snoop whose tag differs from the line held at its index has no effect on state and raises no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until stall is low |
| cpu_op | input | 2 | 0 read, 1 write, 2 replace |
| cpu_addr | input | ADDR_W | Line address {tag, index} |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rdata | output | DATA_W | Read word, valid when the request completes |
| cpu_hit | output | 1 | Request completed as a cache hit |
| cpu_stall | output | 1 | Request not yet complete |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 1 read, 2 read-exclusive, 3 write-back |
| bus_addr | output | ADDR_W | Transaction line address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Grant, completes the transaction this cycle |
| bus_rdata | input | DATA_W | Fill data in the grant cycle |
| snp_valid | input | 1 | Foreign transaction visible on the bus |
| snp_cmd | input | 2 | 1 read, 2 read-exclusive |
| snp_addr | input | ADDR_W | Foreign line address |
| flush_vld | output | 1 | Dirty line supplied in answer to a snoop |
| flush_addr | output | ADDR_W | Flushed line address |
| flush_data | output | DATA_W | Flushed line data |
| line_state | output | 2*LINES | State of every line |

## Verification
Hit, stall and bus request are combinational, so they are due in the same cycle as the request and the grant. The bench drives on the falling edge and samples one nanosecond later. Line-state changes and the flush port are due after the next rising edge, and the bench reads them just after the following falling edge. A miss over a dirty line takes a write-back cycle, one re-evaluation cycle and a fill cycle. The request task grants each request as soon as it appears and logs every transaction in order, so checks compare whole sequences rather than single cycles. The race scenarios withhold grant by hand, to hold the controller in its waiting state while a snoop is applied.

// File: rtl/wb_coh_pkg.sv
package wb_coh_pkg;
   typedef enum logic [1:0] {LS_INV = 2'd0, LS_VAL = 2'd1, LS_MOD = 2'd2} line_st_e;
   typedef enum logic [1:0] {BC_NONE = 2'd0, BC_RD = 2'd1, BC_RDX = 2'd2, BC_WB = 2'd3} bus_cmd_e;
   typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_REPL = 2'd2} cpu_op_e;
   typedef enum logic [1:0] {FS_IDLE = 2'd0, FS_WB = 2'd1, FS_FILL = 2'd2} fsm_st_e;
endpackage

// File: rtl/wb_coh_line_store.sv
module wb_coh_line_store
   import wb_coh_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int TAG_W  = 9,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IDX_W-1:0]   a_idx,
   input  logic [IDX_W-1:0]   b_idx,
   input  logic               p_we,
   input  logic [IDX_W-1:0]   p_idx,
   input  logic [1:0]         p_state,
   input  logic               p_tag_we,
   input  logic [TAG_W-1:0]   p_tag,
   input  logic               p_data_we,
   input  logic [DATA_W-1:0]  p_data,
   input  logic               s_we,
   input  logic [IDX_W-1:0]   s_idx,
   input  logic [1:0]         s_state,
   output logic [1:0]         a_state,
   output logic [TAG_W-1:0]   a_tag,
   output logic [DATA_W-1:0]  a_data,
   output logic [1:0]         b_state,
   output logic [TAG_W-1:0]   b_tag,
   output logic [DATA_W-1:0]  b_data,
   output logic [2*LINES-1:0] state_flat
);
   logic [1:0]        st_arr   [LINES];
   logic [TAG_W-1:0]  tag_arr  [LINES];
   logic [DATA_W-1:0] data_arr [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [1:0]        st_r;
      logic [TAG_W-1:0]  tag_r;
      logic [DATA_W-1:0] data_r;
      // processor update wins; the controller never lets both hit one index
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_r   <= LS_INV;
            tag_r  <= '0;
            data_r <= '0;
         end else if (p_we && p_idx == IDX_W'(g)) begin
            st_r <= p_state;
            if (p_tag_we)  tag_r  <= p_tag;
            if (p_data_we) data_r <= p_data;
         end else if (s_we && s_idx == IDX_W'(g)) begin
            st_r <= s_state;
         end
      end
      assign st_arr[g]   = st_r;
      assign tag_arr[g]  = tag_r;
      assign data_arr[g] = data_r;
      assign state_flat[2*g +: 2] = st_r;
   end

   assign a_state = st_arr[a_idx];
   assign a_tag   = tag_arr[a_idx];
   assign a_data  = data_arr[a_idx];
   assign b_state = st_arr[b_idx];
   assign b_tag   = tag_arr[b_idx];
   assign b_data  = data_arr[b_idx];

   assert_reset_invalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (state_flat == '0));
   assert_one_writer_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(p_we && s_we && p_idx == s_idx));
endmodule

// File: rtl/wb_coh_ctrl_fsm.sv
module wb_coh_ctrl_fsm
   import wb_coh_pkg::*;
#(
   parameter int TAG_W  = 9,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic [1:0]        cpu_op,
   input  logic [TAG_W-1:0]  cpu_tag,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [1:0]        line_st,
   input  logic [TAG_W-1:0]  line_tag,
   input  logic [DATA_W-1:0] line_data,
   input  logic              bus_gnt,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              snp_block,
   output logic              cpu_hit,
   output logic              cpu_stall,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   output logic [1:0]        bus_cmd,
   output logic              bus_old_tag,
   output logic              upd_we,
   output logic [1:0]        upd_state,
   output logic              upd_tag_we,
   output logic              upd_data_we,
   output logic [DATA_W-1:0] upd_data
);
   fsm_st_e st_q, st_d;
   logic    done;
   logic    tag_hit, present;

   assign tag_hit = (line_tag == cpu_tag);
   assign present = (line_st != LS_INV);

   always_comb begin
      st_d        = st_q;
      done        = 1'b0;
      cpu_hit     = 1'b0;
      cpu_rdata   = line_data;
      bus_req     = 1'b0;
      bus_cmd     = BC_NONE;
      bus_old_tag = 1'b0;
      upd_we      = 1'b0;
      upd_state   = line_st;
      upd_tag_we  = 1'b0;
      upd_data_we = 1'b0;
      upd_data    = cpu_wdata;
      unique case (st_q)
         FS_IDLE: if (cpu_req && !snp_block) begin
            unique case (cpu_op)
               OP_RD: begin
                  if (tag_hit && present) begin
                     cpu_hit = 1'b1;
                     done    = 1'b1;
                  end else if (line_st == LS_MOD) st_d = FS_WB;
                  else                            st_d = FS_FILL;
               end
               OP_WR: begin
                  if (tag_hit && line_st == LS_MOD) begin
                     cpu_hit     = 1'b1;
                     done        = 1'b1;
                     upd_we      = 1'b1;
                     upd_state   = LS_MOD;
                     upd_data_we = 1'b1;
                  end else if (line_st == LS_MOD) st_d = FS_WB;
                  else                            st_d = FS_FILL;
               end
               OP_REPL: begin
                  if (line_st == LS_MOD) st_d = FS_WB;
                  else begin
                     done      = 1'b1;
                     upd_we    = (line_st == LS_VAL);
                     upd_state = LS_INV;
                  end
               end
               default: done = 1'b1;
            endcase
         end
         FS_WB: begin
            if (line_st != LS_MOD) st_d = FS_IDLE;   // a snoop already took the dirty copy
            else begin
               bus_req     = 1'b1;
               bus_cmd     = BC_WB;
               bus_old_tag = 1'b1;
               if (bus_gnt) begin
                  upd_we    = 1'b1;
                  upd_state = LS_INV;
                  st_d      = FS_IDLE;
               end
            end
         end
         FS_FILL: begin
            bus_req = 1'b1;
            bus_cmd = (cpu_op == OP_WR) ? BC_RDX : BC_RD;
            if (bus_gnt) begin
               done        = 1'b1;
               upd_we      = 1'b1;
               upd_tag_we  = 1'b1;
               upd_data_we = 1'b1;
               if (cpu_op == OP_WR) begin
                  upd_state = LS_MOD;
               end else begin
                  upd_state = LS_VAL;
                  upd_data  = bus_rdata;
                  cpu_rdata = bus_rdata;
               end
               st_d = FS_IDLE;
            end
         end
         default: st_d = FS_IDLE;
      endcase
   end

   assign cpu_stall = cpu_req && !done;

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= FS_IDLE;
      else        st_q <= st_d;
   end

   assert_hit_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_hit |-> (!bus_req && !cpu_stall));
   assert_wb_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FS_WB && cpu_req) |-> cpu_stall);
endmodule

// File: rtl/wb_coh_snoop_unit.sv
module wb_coh_snoop_unit
   import wb_coh_pkg::*;
#(
   parameter int TAG_W  = 9,
   parameter int IDX_W  = 3,
   parameter int DATA_W = 32,
   localparam int ADDR_W = TAG_W + IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [TAG_W-1:0]  snp_tag,
   input  logic [IDX_W-1:0]  snp_idx,
   input  logic [IDX_W-1:0]  cpu_idx,
   input  logic [1:0]        line_st,
   input  logic [TAG_W-1:0]  line_tag,
   input  logic [DATA_W-1:0] line_data,
   input  logic              bus_gnt,
   output logic              s_we,
   output logic [1:0]        s_state,
   output logic              snp_block,
   output logic              flush_vld,
   output logic [ADDR_W-1:0] flush_addr,
   output logic [DATA_W-1:0] flush_data
);
   logic act, is_rd, is_rdx, dirty;

   assign is_rd  = (snp_cmd == BC_RD);
   assign is_rdx = (snp_cmd == BC_RDX);
   assign act    = snp_valid && !bus_gnt && (is_rd || is_rdx)
                   && (line_tag == snp_tag) && (line_st != LS_INV);
   assign dirty  = (line_st == LS_MOD);

   always_comb begin
      s_we    = 1'b0;
      s_state = line_st;
      if (act && is_rdx) begin
         s_we    = 1'b1;
         s_state = LS_INV;
      end else if (act && dirty) begin
         s_we    = 1'b1;
         s_state = LS_VAL;
      end
   end

   assign snp_block = act && (snp_idx == cpu_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flush_vld  <= 1'b0;
         flush_addr <= '0;
         flush_data <= '0;
      end else begin
         flush_vld <= act && dirty;
         if (act && dirty) begin
            flush_addr <= {line_tag, snp_idx};
            flush_data <= line_data;
         end
      end
   end

   assert_flush_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && !bus_gnt && is_rd && line_st == LS_MOD && line_tag == snp_tag) |=> flush_vld);
   assert_flush_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_vld |-> $past(snp_valid));
endmodule

// File: rtl/wb_coh_ctrl.sv
module wb_coh_ctrl
   import wb_coh_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int LINES  = 8,
   localparam int IDX_W = $clog2(LINES),
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic [1:0]         cpu_op,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   output logic [DATA_W-1:0]  cpu_rdata,
   output logic               cpu_hit,
   output logic               cpu_stall,
   output logic               bus_req,
   output logic [1:0]         bus_cmd,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic [DATA_W-1:0]  bus_wdata,
   input  logic               bus_gnt,
   input  logic [DATA_W-1:0]  bus_rdata,
   input  logic               snp_valid,
   input  logic [1:0]         snp_cmd,
   input  logic [ADDR_W-1:0]  snp_addr,
   output logic               flush_vld,
   output logic [ADDR_W-1:0]  flush_addr,
   output logic [DATA_W-1:0]  flush_data,
   output logic [2*LINES-1:0] line_state
);
   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("wb_coh_ctrl: LINES must be a power of two, at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("wb_coh_ctrl: ADDR_W must exceed the index width");
   end

   logic [IDX_W-1:0]  cpu_idx, snp_idx;
   logic [TAG_W-1:0]  cpu_tag, snp_tag;
   logic [1:0]        a_state, b_state, upd_state, s_state;
   logic [TAG_W-1:0]  a_tag, b_tag;
   logic [DATA_W-1:0] a_data, b_data, upd_data;
   logic              upd_we, upd_tag_we, upd_data_we, s_we, snp_block, bus_old_tag;

   assign cpu_idx = cpu_addr[IDX_W-1:0];
   assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
   assign snp_idx = snp_addr[IDX_W-1:0];
   assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

   wb_coh_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk, .rst_n,
      .a_idx(cpu_idx), .b_idx(snp_idx),
      .p_we(upd_we), .p_idx(cpu_idx), .p_state(upd_state),
      .p_tag_we(upd_tag_we), .p_tag(cpu_tag),
      .p_data_we(upd_data_we), .p_data(upd_data),
      .s_we, .s_idx(snp_idx), .s_state,
      .a_state, .a_tag, .a_data, .b_state, .b_tag, .b_data,
      .state_flat(line_state)
   );

   wb_coh_ctrl_fsm #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_fsm (
      .clk, .rst_n, .cpu_req, .cpu_op, .cpu_tag, .cpu_wdata,
      .line_st(a_state), .line_tag(a_tag), .line_data(a_data),
      .bus_gnt, .bus_rdata, .snp_block,
      .cpu_hit, .cpu_stall, .cpu_rdata,
      .bus_req, .bus_cmd, .bus_old_tag,
      .upd_we, .upd_state, .upd_tag_we, .upd_data_we, .upd_data
   );

   wb_coh_snoop_unit #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
      .clk, .rst_n, .snp_valid, .snp_cmd, .snp_tag, .snp_idx, .cpu_idx,
      .line_st(b_state), .line_tag(b_tag), .line_data(b_data), .bus_gnt,
      .s_we, .s_state, .snp_block, .flush_vld, .flush_addr, .flush_data
   );

   assign bus_addr  = {(bus_old_tag ? a_tag : cpu_tag), cpu_idx};
   assign bus_wdata = a_data;

   assert_rdx_owns_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt && bus_cmd == BC_RDX) |=> (line_state[2*$past(cpu_idx) +: 2] == LS_MOD));
   assert_wb_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt && bus_cmd == BC_WB) |=> (line_state[2*$past(cpu_idx) +: 2] == LS_INV));
endmodule

// File: tb/wb_coh_ctrl_tb.sv
module wb_coh_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic [1:0]  cpu_op = 2'd0;
   logic [11:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_hit, cpu_stall, bus_req;
   logic [1:0]  bus_cmd;
   logic [11:0] bus_addr;
   logic [31:0] bus_wdata;
   logic        bus_gnt = 1'b0;
   logic [31:0] bus_rdata = '0;
   logic        snp_valid = 1'b0;
   logic [1:0]  snp_cmd = 2'd0;
   logic [11:0] snp_addr = '0;
   logic        flush_vld;
   logic [11:0] flush_addr;
   logic [31:0] flush_data;
   logic [15:0] line_state;

   int nchk = 0, nerr = 0, cyc = 0;

   logic [1:0]  log_cmd  [8];
   logic [11:0] log_addr [8];
   logic [31:0] log_data [8];
   int          log_n;
   logic        got_hit;
   logic [31:0] got_rdata;
   logic        got_flush;
   logic [11:0] got_faddr;
   logic [31:0] got_fdata;

   wb_coh_ctrl u_dut (.*);

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         nerr++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   function automatic logic [11:0] mk(input int t, input int i);
      return 12'((t << 3) | i);
   endfunction

   function automatic logic [1:0] lst(input int i);
      return line_state[2*i +: 2];
   endfunction

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   // one processor request, granting every bus request at once
   task automatic run_cpu(input logic [1:0] op, input logic [11:0] a,
                          input logic [31:0] wd, input logic [31:0] fill);
      logic fin = 1'b0;
      log_n = 0;
      got_hit = 1'b0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_op = op; cpu_addr = a; cpu_wdata = wd; bus_rdata = fill;
      for (int k = 0; k < 20; k++) begin
         #1;
         if (bus_req) begin
            if (log_n < 8) begin
               log_cmd[log_n] = bus_cmd; log_addr[log_n] = bus_addr; log_data[log_n] = bus_wdata;
            end
            log_n++;
            bus_gnt = 1'b1;
            #1;
         end
         if (!cpu_stall) begin
            fin = 1'b1; got_hit = cpu_hit; got_rdata = cpu_rdata;
         end
         @(negedge clk);
         bus_gnt = 1'b0;
         if (fin) break;
      end
      cpu_req = 1'b0;
      #1;
      if (!fin) chk("request completion", 0, 1);
   endtask

   task automatic snoop(input logic [1:0] cmd, input logic [11:0] a);
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
      @(negedge clk);
      snp_valid = 1'b0;
      #1;
      got_flush = flush_vld; got_faddr = flush_addr; got_fdata = flush_data;
   endtask

   task automatic t_reset();
      chk("R1 all lines invalid", line_state, 0);
      chk("R1 no stall", cpu_stall, 0);
      chk("R1 no bus request", bus_req, 0);
      chk("R1 no flush", flush_vld, 0);
   endtask

   task automatic t_read_miss();
      run_cpu(2'd0, mk(5, 0), 0, 32'hAAAA0001);
      chk("R2 one transaction", log_n, 1);
      chk("R2 bus read cmd", log_cmd[0], 1);
      chk("R2 bus read addr", log_addr[0], mk(5, 0));
      chk("R2 fill data to cpu", got_rdata, 32'hAAAA0001);
      chk("R2 line valid", lst(0), 1);
      run_cpu(2'd0, mk(5, 0), 0, 32'hDEAD);
      chk("R4 read hit valid no bus", log_n, 0);
      chk("R4 read hit flag", got_hit, 1);
      chk("R4 read hit data", got_rdata, 32'hAAAA0001);
   endtask

   task automatic t_write();
      run_cpu(2'd1, mk(5, 0), 32'h1111_0000, 32'h0);
      chk("R3 upgrade one transaction", log_n, 1);
      chk("R3 upgrade rdx", log_cmd[0], 2);
      chk("R3 upgrade modified", lst(0), 2);
      run_cpu(2'd1, mk(6, 1), 32'h2222_0000, 32'h0);
      chk("R3 write miss rdx", log_cmd[0], 2);
      chk("R3 write miss addr", log_addr[0], mk(6, 1));
      chk("R3 write miss modified", lst(1), 2);
      run_cpu(2'd1, mk(5, 0), 32'h1111_0005, 32'h0);
      chk("R4 write hit no bus", log_n, 0);
      chk("R4 write hit flag", got_hit, 1);
      run_cpu(2'd0, mk(5, 0), 0, 32'h0);
      chk("R4 read hit modified data", got_rdata, 32'h1111_0005);
      chk("R4 read hit modified no bus", log_n, 0);
   endtask

   task automatic t_conflict();
      run_cpu(2'd0, mk(7, 0), 0, 32'h7777_0000);
      chk("R6 read two transactions", log_n, 2);
      chk("R6 writeback first", log_cmd[0], 3);
      chk("R6 writeback old addr", log_addr[0], mk(5, 0));
      chk("R6 writeback data", log_data[0], 32'h1111_0005);
      chk("R6 then bus read", log_cmd[1], 1);
      chk("R6 bus read new addr", log_addr[1], mk(7, 0));
      chk("R6 line valid", lst(0), 1);
      run_cpu(2'd1, mk(8, 1), 32'h8888_0000, 32'h0);
      chk("R6 write writeback first", log_cmd[0], 3);
      chk("R6 write old addr", log_addr[0], mk(6, 1));
      chk("R6 then rdx", log_cmd[1], 2);
      chk("R6 write line modified", lst(1), 2);
   endtask

   task automatic t_replace();
      run_cpu(2'd2, mk(8, 1), 0, 32'h0);
      chk("R5 dirty replace one writeback", log_n, 1);
      chk("R5 writeback cmd", log_cmd[0], 3);
      chk("R5 writeback data", log_data[0], 32'h8888_0000);
      chk("R5 dirty replace invalid", lst(1), 0);
      run_cpu(2'd2, mk(7, 0), 0, 32'h0);
      chk("R5 clean replace silent", log_n, 0);
      chk("R5 clean replace invalid", lst(0), 0);
   endtask

   task automatic t_snoop();
      run_cpu(2'd1, mk(2, 3), 32'h3333_0000, 32'h0);
      snoop(2'd1, mk(2, 3));
      chk("R7 flush on dirty read", got_flush, 1);
      chk("R7 flush addr", got_faddr, mk(2, 3));
      chk("R7 flush data", got_fdata, 32'h3333_0000);
      chk("R7 line valid", lst(3), 1);
      snoop(2'd1, mk(2, 3));
      chk("R8 read on valid no flush", got_flush, 0);
      chk("R8 read on valid unchanged", lst(3), 1);
      snoop(2'd2, mk(9, 3));
      chk("R11 other tag no flush", got_flush, 0);
      chk("R11 other tag unchanged", lst(3), 1);
      snoop(2'd2, mk(2, 3));
      chk("R8 rdx on valid invalidates", lst(3), 0);
      chk("R8 rdx on valid no flush", got_flush, 0);
      run_cpu(2'd1, mk(2, 4), 32'h4444_0000, 32'h0);
      snoop(2'd2, mk(2, 4));
      chk("R8 rdx on dirty flush", got_flush, 1);
      chk("R8 rdx on dirty data", got_fdata, 32'h4444_0000);
      chk("R8 rdx on dirty invalid", lst(4), 0);
   endtask

   task automatic t_upgrade_race();
      run_cpu(2'd0, mk(3, 5), 0, 32'h5555_0000);
      @(negedge clk);
      cpu_req = 1'b1; cpu_op = 2'd1; cpu_addr = mk(3, 5); cpu_wdata = 32'h5555_AAAA;
      bus_rdata = 32'hBAD0_BAD0;
      @(negedge clk);
      #1;
      chk("R9 rdx pending", {bus_req, bus_cmd}, {1'b1, 2'd2});
      snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = mk(3, 5);
      @(negedge clk);
      snp_valid = 1'b0;
      #1;
      chk("R9 line dropped to invalid", lst(5), 0);
      chk("R9 still stalled", cpu_stall, 1);
      bus_gnt = 1'b1;
      #1;
      chk("R9 completes at grant", cpu_stall, 0);
      @(negedge clk);
      bus_gnt = 1'b0; cpu_req = 1'b0;
      #1;
      chk("R9 line modified", lst(5), 2);
      run_cpu(2'd0, mk(3, 5), 0, 32'h0);
      chk("R9 written word kept", got_rdata, 32'h5555_AAAA);
   endtask

   task automatic t_wb_snoop();
      run_cpu(2'd1, mk(1, 6), 32'h6666_0000, 32'h0);
      run_cpu(2'd1, mk(2, 7), 32'h7777_7777, 32'h0);
      @(negedge clk);
      cpu_req = 1'b1; cpu_op = 2'd2; cpu_addr = mk(1, 6);
      @(negedge clk);
      #1;
      chk("R10 writeback pending", {bus_req, bus_cmd}, {1'b1, 2'd3});
      chk("R10 stalled during writeback", cpu_stall, 1);
      snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = mk(2, 7);
      @(negedge clk);
      snp_valid = 1'b0;
      #1;
      chk("R10 other index flushed", flush_vld, 1);
      chk("R10 flush data", flush_data, 32'h7777_7777);
      chk("R10 other index valid", lst(7), 1);
      chk("R10 still stalled", cpu_stall, 1);
      chk("R10 victim still modified", lst(6), 2);
      bus_gnt = 1'b1;
      @(negedge clk);
      bus_gnt = 1'b0;
      #1;
      chk("R10 replace completes", cpu_stall, 0);
      @(negedge clk);
      cpu_req = 1'b0;
      #1;
      chk("R5 victim invalid after writeback", lst(6), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_read_miss();
      t_write();
      t_conflict();
      t_replace();
      t_snoop();
      t_upgrade_race();
      t_wb_snoop();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule